// File: doc/BRIEF.md
# Interrupt Daisy-Chain Priority Unit

This block decides when a peripheral may claim an interrupt acknowledge in a chain of interrupt sources wired in priority order. Several internal sources raise pending flags, each gated by its own enable bit. The block merges them into one active-low request line, modelled as a drive-low-or-release output. A fixed order picks the winning source. The block passes a chain-enable signal on to the lower-priority neighbour only when neither it nor any higher-priority device needs the processor.

The acknowledge strobe is registered on the rising edge of the peripheral clock. When an acknowledge begins, the block freezes two things for the whole window: whether it is requesting, and which vector it would supply. During that window a pending request holds the downstream chain enable low. Outside an acknowledge, a pending request has no effect on the chain. If the upstream chain enable is high and the read strobe goes low inside the window, the block drives its vector onto the data bus and marks itself under service. The under-service mark releases the request line and keeps the downstream chain blocked until a reset-of-service command clears it.

Top module: `irq_chain_unit`

## Requirements
- R1: `irq_n_o` is low exactly when at least one source has both its pending bit and its enable bit set and the block is not under service. Otherwise it is high, meaning released.
- R2: The lowest-numbered requesting source wins. The vector is made of two parts. Bits [7:2] come from the vector register, which is loaded from `vec_wdata_i` on a clock edge where `vec_wr_i` is high. Bits [1:0] hold the index of the winning source, with the default of 4 sources.
- R3: With no acknowledge in progress, `chain_out_o` equals `chain_in_i` while the block is not under service, whatever the pending bits are. It is low while the block is under service.
- R4: The first registered clock edge of an acknowledge captures whether a source was requesting. If one was, and the block was not under service, `chain_out_o` stays low for the rest of the acknowledge. This holds even if the pending bits change during the acknowledge.
- R5: `ack_n_i` only takes effect through a register. Driving it low changes no output until the next rising clock edge.
- R6: `dbus_oe_o` is high only when all of the following hold: the registered acknowledge is active, `rd_n_i` is low, `chain_in_i` is high, and a request was captured at the start of the acknowledge. At all other times `dbus_oe_o` is low and `dbus_o` is zero.
- R7: A clock edge on which `dbus_oe_o` is high sets the under-service state.
- R8: A clock edge with `rst_ius_i` high clears the under-service state. If that edge also sets the state under R7, the set wins.
- R9: If `chain_in_i` is low during an acknowledge, the block supplies no vector and does not enter service.
- R10: After reset, the block is in this state: `irq_n_o` is released, `dbus_oe_o` is low, `chain_out_o` follows `chain_in_i`, and the vector register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pend_i | input | NUM_SRC | Pending flags of the internal sources |
| src_en_i | input | NUM_SRC | Per-source interrupt enables |
| vec_wr_i | input | 1 | Load strobe for the vector register |
| vec_wdata_i | input | 8 | New vector register value |
| rst_ius_i | input | 1 | Reset-of-service command |
| chain_in_i | input | 1 | Chain enable from the higher-priority neighbour |
| ack_n_i | input | 1 | Interrupt acknowledge strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| irq_n_o | output | 1 | Interrupt request, low = drive low, high = release |
| chain_out_o | output | 1 | Chain enable to the lower-priority neighbour |
| dbus_oe_o | output | 1 | Data bus drive enable |
| dbus_o | output | 8 | Vector driven onto the data bus |

## Verification
The sweep covers every pending and enable combination, with the upstream chain enable both high and low. It targets four ways the block could go wrong.

- A design that let pending flags block the chain outside an acknowledge would stall lower-priority devices even when nobody is acknowledging.
- A design that did not freeze its decision would re-open the chain when the pending bits drop mid-acknowledge. Two devices could then answer the same read.
- A design that used the acknowledge strobe without registering it would react before the clock edge.
- A design with the wrong priority would place the wrong index in the vector's low bits.

Separate cases check two more things. A reset-of-service command that arrives on the same edge as a new service must lose. Service must never begin while the upstream chain enable is low.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    localparam int VEC_W = 8;

    typedef struct packed {
        logic             ius;   // under service
        logic             snap;  // request captured at acknowledge start
        logic [VEC_W-1:0] vec;   // vector latched at acknowledge start
        logic [VEC_W-1:0] vreg;  // programmed vector register
    } chain_state_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);
    logic [N:0]   seen;
    logic [N-1:0] gnt;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_stage
        assign seen[i+1] = seen[i] | req_i[i];
        assign gnt[i]    = req_i[i] & ~seen[i];
    end

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            if (gnt[k]) idx_o = idx_o | IW'(k);
        end
    end

    assign valid_o = seen[N];
endmodule

// File: rtl/irq_ack_sampler.sv
module irq_ack_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n_i,
    output logic ack_q_o,
    output logic ack_start_o,
    output logic ack_next_o
);
    logic ack_d, ack_q;

    always_comb begin
        ack_d = ~ack_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= ack_d;
    end

    assign ack_q_o     = ack_q;
    assign ack_next_o  = ack_d;
    assign ack_start_o = ack_d & ~ack_q;
endmodule

// File: rtl/irq_chain_unit.sv
module irq_chain_unit
    import irq_chain_pkg::*;
#(
    parameter int NUM_SRC = 4,
    localparam int IW     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               vec_wr_i,
    input  logic [VEC_W-1:0]   vec_wdata_i,
    input  logic               rst_ius_i,
    input  logic               chain_in_i,
    input  logic               ack_n_i,
    input  logic               rd_n_i,
    output logic               irq_n_o,
    output logic               chain_out_o,
    output logic               dbus_oe_o,
    output logic [VEC_W-1:0]   dbus_o
);
    chain_state_t s_d, s_q;

    logic [NUM_SRC-1:0] req_vec;
    logic               enc_valid;
    logic [IW-1:0]      enc_idx;
    logic               ack_q, ack_start, ack_next;
    logic               grant;

    assign req_vec = src_pend_i & src_en_i;

    irq_prio_enc #(.N(NUM_SRC), .IW(IW)) u_enc (
        .req_i   (req_vec),
        .valid_o (enc_valid),
        .idx_o   (enc_idx)
    );

    irq_ack_sampler u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_n_i     (ack_n_i),
        .ack_q_o     (ack_q),
        .ack_start_o (ack_start),
        .ack_next_o  (ack_next)
    );

    always_comb begin
        s_d   = s_q;
        grant = ack_q & ~rd_n_i & chain_in_i & s_q.snap;

        if (vec_wr_i) s_d.vreg = vec_wdata_i;

        if (ack_start) begin
            s_d.snap = enc_valid & ~s_q.ius;
            s_d.vec  = {s_q.vreg[VEC_W-1:IW], enc_idx};
        end else if (!ack_next) begin
            s_d.snap = 1'b0;
        end

        s_d.ius = (s_q.ius & ~rst_ius_i) | grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_n_o     = ~(enc_valid & ~s_q.ius);
    assign chain_out_o = chain_in_i & ~s_q.ius & ~(ack_q & s_q.snap);
    assign dbus_oe_o   = grant;
    assign dbus_o      = grant ? s_q.vec : '0;

    // R1
    ius_releases_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ius |-> irq_n_o);

    // R3
    ius_blocks_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ius |-> !chain_out_o);

    // R4
    chain_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && $past(ack_q) && $stable(chain_in_i) && !$past(rst_ius_i))
        |-> $stable(chain_out_o));

    // R6
    vector_blocks_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe_o |-> !chain_out_o);

    // R7
    service_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe_o |=> irq_n_o);

    // R2
    winner_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |-> ((req_vec & ((NUM_SRC'(1) << enc_idx) - NUM_SRC'(1))) == '0));
endmodule

// File: tb/irq_chain_unit_tb.sv
module irq_chain_unit_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_pend_i = '0;
    logic [N-1:0] src_en_i = '0;
    logic         vec_wr_i = 1'b0;
    logic [7:0]   vec_wdata_i = '0;
    logic         rst_ius_i = 1'b0;
    logic         chain_in_i = 1'b1;
    logic         ack_n_i = 1'b1;
    logic         rd_n_i = 1'b1;
    logic         irq_n_o, chain_out_o, dbus_oe_o;
    logic [7:0]   dbus_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #10 clk = ~clk;

    irq_chain_unit #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_pend_i(src_pend_i), .src_en_i(src_en_i),
        .vec_wr_i(vec_wr_i), .vec_wdata_i(vec_wdata_i), .rst_ius_i(rst_ius_i),
        .chain_in_i(chain_in_i), .ack_n_i(ack_n_i), .rd_n_i(rd_n_i),
        .irq_n_o(irq_n_o), .chain_out_o(chain_out_o), .dbus_oe_o(dbus_oe_o), .dbus_o(dbus_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk); #1;
    endtask

    function automatic logic [1:0] lowest(input logic [3:0] r);
        logic [1:0] idx = 2'd0;
        for (int k = N - 1; k >= 0; k--) if (r[k]) idx = 2'(k);
        return idx;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 irq", {7'd0, irq_n_o}, 8'd1);
        chk("R10 oe", {7'd0, dbus_oe_o}, 8'd0);
        chk("R10 chain", {7'd0, chain_out_o}, 8'd1);
        @(negedge clk); rst_n = 1'b1;
        src_pend_i = 4'b0001; src_en_i = 4'b0001;
        @(negedge clk); ack_n_i = 1'b0;
        @(negedge clk); rd_n_i = 1'b0; #1;
        chk("R10 vreg zero", dbus_o, 8'h00);
        @(negedge clk); rd_n_i = 1'b1; ack_n_i = 1'b1; rst_ius_i = 1'b1;
        @(negedge clk); rst_ius_i = 1'b0;

        for (int ci = 0; ci < 2; ci++) begin
            for (int pe = 0; pe < 256; pe++) begin
                logic [3:0] p, e;
                logic       rq, srv;
                logic [7:0] ev;
                p   = pe[7:4];
                e   = pe[3:0];
                rq  = |(p & e);
                srv = rq & ci[0];
                ev  = (8'(pe) & 8'hFC) | {6'd0, lowest(p & e)};

                @(negedge clk);
                src_pend_i = p; src_en_i = e; chain_in_i = ci[0];
                vec_wr_i = 1'b1; vec_wdata_i = 8'(pe); rst_ius_i = 1'b1;
                after_edge();
                chk("R1 irq level", {7'd0, irq_n_o}, {7'd0, ~rq});
                chk("R3 chain idle", {7'd0, chain_out_o}, {7'd0, ci[0]});

                @(negedge clk);
                vec_wr_i = 1'b0; rst_ius_i = 1'b0; ack_n_i = 1'b0; #1;
                chk("R5 before edge", {7'd0, chain_out_o}, {7'd0, ci[0]});
                after_edge();
                chk("R4 chain in ack", {7'd0, chain_out_o}, {7'd0, ci[0] & ~rq});
                chk("R6 oe no read", {7'd0, dbus_oe_o}, 8'd0);

                @(negedge clk); src_pend_i = '0;
                after_edge();
                chk("R4 frozen", {7'd0, chain_out_o}, {7'd0, ci[0] & ~rq});
                chk("R1 no pend", {7'd0, irq_n_o}, 8'd1);

                @(negedge clk); rd_n_i = 1'b0; #1;
                chk("R6 oe read", {7'd0, dbus_oe_o}, {7'd0, srv});
                chk("R2 vector", dbus_o, srv ? ev : 8'h00);

                @(posedge clk);
                @(negedge clk); rd_n_i = 1'b1; ack_n_i = 1'b1; src_pend_i = p;
                after_edge();
                chk("R7 irq released", {7'd0, irq_n_o}, {7'd0, ~(rq & ~srv)});
                chk(ci[0] ? "R7 chain after" : "R9 chain after",
                    {7'd0, chain_out_o}, {7'd0, ci[0] & ~srv});

                @(negedge clk); rst_ius_i = 1'b1;
                after_edge();
                chk("R8 cleared chain", {7'd0, chain_out_o}, {7'd0, ci[0]});
                chk("R8 cleared irq", {7'd0, irq_n_o}, {7'd0, ~rq});
                @(negedge clk); rst_ius_i = 1'b0;
            end
        end

        // R8 set wins over clear on the same edge
        @(negedge clk); src_pend_i = 4'b0100; src_en_i = 4'b1111; chain_in_i = 1'b1;
        ack_n_i = 1'b0;
        @(negedge clk); rd_n_i = 1'b0; rst_ius_i = 1'b1;
        @(negedge clk); rd_n_i = 1'b1; ack_n_i = 1'b1; rst_ius_i = 1'b0;
        after_edge();
        chk("R8 set wins chain", {7'd0, chain_out_o}, 8'd0);
        chk("R8 set wins irq", {7'd0, irq_n_o}, 8'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule